// File: doc/BRIEF.md
# Programmable-Level Interrupt Controller

This block collects up to 63 interrupt request lines (source numbers 1 to 63; position 0 is reserved) and gates them with a mask register. Every source that is not hardwired carries a small control byte. It sets the interrupt level (1 to 7) and a 3-bit priority within that level. The controller drives a decoded seven-line pending-level output towards a processor core. Each line is high while at least one unmasked, requesting source sits at that level.

Sources 1 to 7 are hardwired. Source k always belongs to level k, and within that level it ranks half-way between programmable priorities 3 and 4. A processor acknowledges an interrupt with an ordinary byte read in the top 32 bytes of the controller's address space, and address bits [4:2] name the level. The controller answers the read by itself. It returns 64 plus the number of the best active source at that level, or the spurious vector 24 when that level has nothing active.

Top module: `intc_top`

## Requirements
- R1: After a synchronous active-low reset, every mask bit reads 1 (mask bytes at addresses 0x40 to 0x47, byte 0x40 holding bits 7:0), every control byte reads 0, the pending output is all zero and read-valid is low.
- R2: Address n (0x00 to 0x3F) holds the control byte of source n, with level in bits [5:3] and priority in bits [2:0]. Bits [7:6] read 0. For sources 0 to 7 the control byte reads 0 and writes to it are ignored.
- R3: A source whose mask bit is 1 is ignored. It raises no pending line and is never returned by an acknowledge.
- R4: Pending line L (bit L of the [7:1] output) is high one clock after an unmasked, requesting source has level L, and is low one clock after no such source exists. A source with level 0 never raises a line.
- R5: A byte read at address 0xE0 | (L << 2) returns 64 + n, where n is the winning active source at level L. Writes to addresses 0xE0 to 0xFF have no effect on any register.
- R6: At one level, a source with a higher programmed priority wins over one with a lower priority.
- R7: When two active sources at one level have the same priority, the source with the higher number wins.
- R8: A hardwired source beats programmable priorities 0 to 3 at its level and loses to priorities 4 to 7.
- R9: An acknowledge of a level that has no active source returns 24. Level 0 always returns 24.
- R10: Read data and read-valid appear exactly one clock after the read strobe. Read-valid is a single-cycle pulse for each strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 64 | Request lines; bit n is source n, bit 0 unused |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe (register read or acknowledge) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data / vector |
| bus_rvalid | output | 1 | High for one clock, one clock after bus_rd |
| pend_lvl | output | 7 | Decoded pending levels, bit L for level L (indices 7:1) |

## Verification
The bench builds the block with its default parameters: 64 source positions, 7 hardwired sources, 8-bit addressing and vector base 64. These values make the complete byte-wide mask layout reachable, together with the hardwired sources and the top-of-space acknowledge window. Programmable sources are placed at the same level as a hardwired source, so the half-step rank can be probed from both sides. Equal-priority ties, level-0 sources and empty levels are also set up, so the spurious path is exercised along with the normal vector path.

// File: rtl/intc_pkg.sv
// Package: shared constants and types of the interrupt controller.
// Assumes byte-wide register access and eight interrupt levels (0 = none).
package intc_pkg;
    localparam int LVL_W      = 3;
    localparam int PRIO_W     = 3;
    localparam int NUM_LVL    = 1 << LVL_W;
    localparam int RANK_W     = PRIO_W + 1;
    localparam int BYTE_W     = 8;

    // Per-source configuration as stored in the register file.
    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;
endpackage

// File: rtl/intc_regs.sv
// Register file: per-source control bytes and the byte-sliced mask.
// Assumes NUM_SRC is a multiple of 8 and no larger than the control window.
// Sources 0..NUM_FIXED have no writable control byte.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_FIXED = 7,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             wdata,
    output src_cfg_t [NUM_SRC-1:0]        cfg_o,
    output logic [NUM_SRC-1:0]            mask_o,
    output logic [BYTE_W-1:0]             rdata_o
);
    localparam int MASK_BYTES = NUM_SRC / BYTE_W;
    localparam int MASK_BASE  = NUM_SRC;

    logic ctrl_win;
    logic mask_win;
    logic [ADDR_W-1:0] mask_off;

    // Decode which window the address falls in.
    always_comb begin
        ctrl_win = (int'(addr) < NUM_SRC);
        mask_win = (int'(addr) >= MASK_BASE) && (int'(addr) < MASK_BASE + MASK_BYTES);
        mask_off = addr - ADDR_W'(MASK_BASE);
    end

    // One control byte per programmable source; fixed ones tie to zero.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
        if (n <= NUM_FIXED) begin : g_fixed
            assign cfg_o[n] = '0;
        end else begin : g_prog
            src_cfg_t cfg_q;
            // Hold level and priority of source n.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q <= '0;
                else if (wr_en && ctrl_win && (int'(addr) == n))
                    cfg_q <= src_cfg_t'(wdata[LVL_W+PRIO_W-1:0]);
            end
            assign cfg_o[n] = cfg_q;
        end
    end

    // Mask bytes; reset value masks everything.
    for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
        logic [BYTE_W-1:0] mbyte_q;
        // Hold mask bits 8b+7 .. 8b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mbyte_q <= '1;
            else if (wr_en && mask_win && (int'(mask_off) == b))
                mbyte_q <= wdata;
        end
        assign mask_o[b*BYTE_W +: BYTE_W] = mbyte_q;
    end

    // Combinational register read-back.
    always_comb begin
        rdata_o = '0;
        if (ctrl_win) begin
            for (int n = 0; n < NUM_SRC; n++)
                if (int'(addr) == n)
                    rdata_o = {{(BYTE_W-LVL_W-PRIO_W){1'b0}}, cfg_o[n]};
        end else if (mask_win) begin
            for (int b = 0; b < MASK_BYTES; b++)
                if (int'(mask_off) == b)
                    rdata_o = mask_o[b*BYTE_W +: BYTE_W];
        end
    end

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask_o));

    assert_fixed_cfg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[NUM_FIXED] == '0) && (cfg_o[0] == '0));
endmodule

// File: rtl/intc_level_arb.sv
// Level arbiter: picks the best active source for one interrupt level.
// Rank is priority doubled; a hardwired source ranks 7 (between 3 and 4).
// Scanning upward with >= makes the higher source number win ties.
module intc_level_arb
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LEVEL   = 1,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         active,
    input  logic [NUM_SRC-1:0]         fixed,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]  eff_lvl,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] eff_prio,
    output logic                       hit,
    output logic [IDX_W-1:0]           win_idx
);
    localparam logic [RANK_W-1:0] FIXED_RANK = RANK_W'(7);

    logic [RANK_W-1:0] best;
    logic [RANK_W-1:0] rank;

    // Scan all sources and keep the highest-ranked one at this level.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        best    = '0;
        rank    = '0;
        for (int n = 1; n < NUM_SRC; n++) begin
            rank = fixed[n] ? FIXED_RANK : {eff_prio[n], 1'b0};
            if (active[n] && (int'(eff_lvl[n]) == LEVEL) && (!hit || rank >= best)) begin
                hit     = 1'b1;
                best    = rank;
                win_idx = IDX_W'(n);
            end
        end
    end

    assert_winner_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (active[win_idx] && (int'(eff_lvl[win_idx]) == LEVEL)));

    assert_idle_no_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> !hit);
endmodule

// File: rtl/intc_top.sv
// Interrupt controller top: recognition, per-level prioritization,
// decoded pending output and self-served acknowledge reads.
// Assumes acknowledge reads sit in the top 32 bytes of an 8-bit space,
// with the level in address bits [4:2].
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_FIXED = 7,
    parameter int ADDR_W    = 8,
    parameter int VEC_BASE  = 64,
    parameter int VEC_SPUR  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 bus_rvalid,
    output logic [7:1]           pend_lvl
);
    localparam int IDX_W = $clog2(NUM_SRC);

    src_cfg_t [NUM_SRC-1:0]          cfg;
    logic [NUM_SRC-1:0]              mask;
    logic [7:0]                      reg_rdata;
    logic [NUM_SRC-1:0]              active;
    logic [NUM_SRC-1:0]              fixed;
    logic [NUM_SRC-1:0][LVL_W-1:0]   eff_lvl;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  eff_prio;
    logic [NUM_LVL-1:0]              lvl_hit;
    logic [NUM_LVL-1:0][IDX_W-1:0]   lvl_win;
    logic                            ack_sel;
    logic [LVL_W-1:0]                ack_lvl;
    logic                            reg_wr;

    // Acknowledge window decode; writes there reach no register.
    always_comb begin
        ack_sel = (bus_addr[ADDR_W-1:5] == '1);
        ack_lvl = bus_addr[4:2];
        reg_wr  = bus_wr && !ack_sel;
    end

    intc_regs #(
        .NUM_SRC   (NUM_SRC),
        .NUM_FIXED (NUM_FIXED),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .rdata_o (reg_rdata)
    );

    // Recognition: request gated by mask, effective level per source.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        if (n == 0) begin : g_rsvd
            assign fixed[n]    = 1'b0;
            assign eff_lvl[n]  = '0;
            assign eff_prio[n] = '0;
            assign active[n]   = 1'b0;
        end else if (n <= NUM_FIXED) begin : g_hard
            assign fixed[n]    = 1'b1;
            assign eff_lvl[n]  = LVL_W'(n);
            assign eff_prio[n] = '0;
            assign active[n]   = irq_req[n] && !mask[n];
        end else begin : g_prog
            assign fixed[n]    = 1'b0;
            assign eff_lvl[n]  = cfg[n].lvl;
            assign eff_prio[n] = cfg[n].prio;
            assign active[n]   = irq_req[n] && !mask[n];
        end
    end

    // Prioritization: one arbiter per nonzero level.
    assign lvl_hit[0] = 1'b0;
    assign lvl_win[0] = '0;
    for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
        intc_level_arb #(
            .NUM_SRC (NUM_SRC),
            .LEVEL   (l),
            .IDX_W   (IDX_W)
        ) arb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active),
            .fixed    (fixed),
            .eff_lvl  (eff_lvl),
            .eff_prio (eff_prio),
            .hit      (lvl_hit[l]),
            .win_idx  (lvl_win[l])
        );
    end

    // Registered decoded pending-level output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_lvl <= '0;
        else
            pend_lvl <= lvl_hit[NUM_LVL-1:1];
    end

    // Registered read path: register data or acknowledge vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                if (!ack_sel)
                    bus_rdata <= reg_rdata;
                else if (lvl_hit[ack_lvl])
                    bus_rdata <= 8'(VEC_BASE) + 8'(lvl_win[ack_lvl]);
                else
                    bus_rdata <= 8'(VEC_SPUR);
            end
        end
    end

    assert_rvalid_follows_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    assert_ack_vector_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ack_sel) |=> ((bus_rdata == 8'(VEC_SPUR)) || (bus_rdata > 8'(VEC_BASE))));

    assert_masked_no_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~mask) == '0) |=> (pend_lvl == '0));
endmodule

// File: tb/intc_top_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares.
module intc_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [7:1]  pend_lvl;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pend_lvl   (pend_lvl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare on every valid read.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected read-valid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic req(input int n, input logic v);
        @(negedge clk);
        irq_req[n] = v;
    endtask

    task automatic chk_pend(input logic [7:1] e, input string tag);
        repeat (2) @(negedge clk);
        check(pend_lvl == e, tag, pend_lvl, e);
    endtask

    function automatic logic [7:0] ack(input int lvl);
        return 8'hE0 | 8'(lvl << 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pend_lvl == '0, "R1 pending after reset", pend_lvl, 0);
        check(bus_rvalid == 1'b0, "R1 rvalid after reset", bus_rvalid, 0);
        rd(8'h40, 8'hFF, "R1 mask byte 0");
        rd(8'h47, 8'hFF, "R1 mask byte 7");
        rd(8'h10, 8'h00, "R1 control byte zero");

        wr(8'h10, 8'hFF);
        rd(8'h10, 8'h3F, "R2 top bits read zero");
        check(bus_rvalid == 1'b1, "R10 valid one clock after strobe", bus_rvalid, 1);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R10 valid is a pulse", bus_rvalid, 0);
        wr(8'h03, 8'h2A);
        rd(8'h03, 8'h00, "R2 fixed source byte ignored");
        wr(8'h00, 8'hFF);
        rd(8'h00, 8'h00, "R2 reserved byte ignored");

        // Source 16: level 7, priority 7, still masked.
        req(16, 1'b1);
        req(0, 1'b1);
        chk_pend(7'b0000000, "R3 masked source no pending");
        rd(ack(7), 8'd24, "R3 masked source not acknowledged");

        wr(8'h42, 8'hFE);
        chk_pend(7'b1000000, "R4 level 7 pending");
        rd(8'h42, 8'hFE, "R3 mask byte readback");
        rd(ack(7), 8'd80, "R5 vector 64+16");

        // Source 20: level 7 priority 3, then priority 7.
        wr(8'h14, 8'h3B);
        wr(8'h42, 8'hEE);
        req(20, 1'b1);
        rd(ack(7), 8'd80, "R6 higher priority wins");
        wr(8'h14, 8'h3F);
        rd(ack(7), 8'd84, "R7 tie goes to higher number");

        // Level 5: fixed source 5 against priorities 3 and 4.
        wr(8'h18, 8'h2B);
        wr(8'h19, 8'h2C);
        wr(8'h40, 8'hDF);
        wr(8'h43, 8'hFC);
        req(5, 1'b1);
        rd(ack(5), 8'd69, "R8 fixed source alone");
        req(24, 1'b1);
        rd(ack(5), 8'd69, "R8 fixed beats priority 3");
        req(25, 1'b1);
        rd(ack(5), 8'd89, "R8 priority 4 beats fixed");
        chk_pend(7'b1010000, "R4 levels 7 and 5 pending");

        // Source 30 at level 0 never interrupts.
        wr(8'h1E, 8'h05);
        wr(8'h43, 8'hBC);
        req(30, 1'b1);
        rd(ack(0), 8'd24, "R9 level 0 spurious");
        rd(ack(2), 8'd24, "R9 empty level spurious");
        chk_pend(7'b1010000, "R4 level 0 source raises nothing");

        wr(8'h42, 8'hFF);
        chk_pend(7'b0010000, "R3 remasking drops level 7");
        rd(ack(7), 8'd24, "R3 remasked level spurious");

        wr(8'hFD, 8'h00);
        rd(8'h40, 8'hDF, "R5 write to acknowledge window ignored");
        rd(8'h1E, 8'h05, "R5 control byte untouched by window write");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule